// File: doc/BRIEF.md
# Display Link Operating Mode Controller

This block is the control-side sequencer of a serial display link host. Software selects an operating mode and raises a power-up bit through a small word-addressed register port. The controller then hands the link over from the engine that is running to the engine that the new mode needs. It confirms the switch by updating a mode status word that software polls. It also drives three separate active-low subsystem resets, a manual-timing select, and a read-only word of core activity flags.

Two engines sit downstream: a pixel engine, which serves video, video test, data stream and data stream test, and a command engine. Each is enabled by a level request and answers with a level acknowledge. A mode switch first withdraws the outgoing engine's request. It waits until that engine has dropped its acknowledge and reports not busy. Only then does it raise the incoming engine's request, and the status word changes once that engine acknowledges. Idle and automatic calculation use no engine, so they commit as soon as the outgoing engine is quiet.

The register port is plain: a write is taken on any clock edge where `wr_en` is high, and reads are combinational from `rd_addr`. Word indices are: 0 power, 1 soft reset, 2 mode request, 3 mode status (read-only), 4 core status (read-only), 5 manual timing. Writes to the read-only words and to unmapped indices have no effect, and unmapped indices read as zero.

Top module: `link_mode_ctrl`

## Requirements
- R1: Mode codes are idle 0, automatic calculation 1, command 2, video 3, data stream 4, video test 5, data stream test 6. A write to word 2 stores the code, and word 2 reads it back in bits 2:0.
- R2: Word 3 and `mode_status_o` report the mode in effect, and they reach the requested code once the switch handshake completes.
- R3: A write to word 2 whose value is not 0 to 6 is ignored: word 2 and the mode status keep their previous values.
- R4: Word 1 holds three active-low resets: system at bit 2, PHY at bit 1, pixel interface at bit 0. They drive `sys_rst_n_o`, `phy_rst_n_o` and `pix_rst_n_o`, and all are released (value 7) after hardware reset.
- R5: While any of the three soft resets is asserted, the mode status is idle and neither engine request is high. Once all three are released, the stored request is entered again.
- R6: Power-up is bit 0 of word 0, and it is 0 after reset. While it is 0, the status is idle and no engine is requested, so command mode is entered only after it is set. Clearing it drops the status to idle and removes the engine request at once.
- R7: A switch does not raise the incoming engine's request, and does not change the status, until the outgoing engine's acknowledge and busy are both low. Until the incoming engine acknowledges, the status keeps the old mode.
- R8: In a settled mode, the pixel engine is requested for modes 3 to 6 and the command engine for mode 2. Neither is requested for modes 0 and 1, and the two requests are never high together.
- R9: Word 4 carries: bit 0 core busy (either engine busy or a switch in progress), bit 1 either FIFO not empty, bit 8 pixel busy, bit 9 pixel FIFO not empty, bit 16 command busy, bit 17 command FIFO not empty, bit 18 command read data available. All other bits are zero.
- R10: Bit 0 of word 5 is the manual timing select. It reads back and drives `manual_timing_o`, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register word index for writes |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register word index for reads |
| rd_data | output | DATA_W | Combinational read data |
| pix_busy_i | input | 1 | Pixel engine busy |
| pix_fifo_nempty_i | input | 1 | Pixel engine FIFOs not empty |
| cmd_busy_i | input | 1 | Command engine busy |
| cmd_fifo_nempty_i | input | 1 | Command engine FIFOs not empty |
| cmd_rd_avail_i | input | 1 | Command read data available |
| pix_ack_i | input | 1 | Pixel engine acknowledge |
| cmd_ack_i | input | 1 | Command engine acknowledge |
| pix_req_o | output | 1 | Pixel engine enable request |
| cmd_req_o | output | 1 | Command engine enable request |
| sys_rst_n_o | output | 1 | System soft reset, active low |
| phy_rst_n_o | output | 1 | PHY soft reset, active low |
| pix_rst_n_o | output | 1 | Pixel interface soft reset, active low |
| manual_timing_o | output | 1 | Manual timing select |
| mode_status_o | output | 3 | Mode currently in effect |

## Verification
The hardest case to reach is a switch that is halfway through. The old mode is still reported while the outgoing engine is draining, or while the incoming engine has not yet answered. The bench holds the command engine's busy input high during a command-to-video request, and then, in a separate step, stops its engine model from acknowledging during a video-to-data-stream request. In each case it checks that the status and the engine requests hold still for many cycles. It then releases the condition and polls for the commit.

// File: rtl/link_mode_pkg.sv
package link_mode_pkg;

  typedef enum logic [2:0] {
    M_IDLE        = 3'd0,
    M_AUTOCALC    = 3'd1,
    M_CMD         = 3'd2,
    M_VIDEO       = 3'd3,
    M_STREAM      = 3'd4,
    M_VIDEO_TEST  = 3'd5,
    M_STREAM_TEST = 3'd6
  } mode_e;

  localparam int unsigned MODE_LAST = 6;

  typedef enum logic [1:0] {
    ENG_NONE = 2'd0,
    ENG_PIX  = 2'd1,
    ENG_CMD  = 2'd2
  } eng_e;

  typedef enum logic [1:0] {
    S_HOLD   = 2'd0,
    S_DRAIN  = 2'd1,
    S_ENGAGE = 2'd2
  } seq_e;

  // register word indices
  localparam int unsigned REG_POWER  = 0;
  localparam int unsigned REG_SOFT   = 1;
  localparam int unsigned REG_MODE   = 2;
  localparam int unsigned REG_STATUS = 3;
  localparam int unsigned REG_CORE   = 4;
  localparam int unsigned REG_MANUAL = 5;

  // soft reset bit positions
  localparam int unsigned SRST_PIX = 0;
  localparam int unsigned SRST_PHY = 1;
  localparam int unsigned SRST_SYS = 2;

  // core status flag positions
  localparam int unsigned CF_CORE_BUSY  = 0;
  localparam int unsigned CF_CORE_FIFO  = 1;
  localparam int unsigned CF_PIX_BUSY   = 8;
  localparam int unsigned CF_PIX_FIFO   = 9;
  localparam int unsigned CF_CMD_BUSY   = 16;
  localparam int unsigned CF_CMD_FIFO   = 17;
  localparam int unsigned CF_CMD_RDAVL  = 18;
  localparam int unsigned CF_MIN_WIDTH  = 19;

  function automatic eng_e engine_of(mode_e m);
    case (m)
      M_CMD:                                   return ENG_CMD;
      M_VIDEO, M_STREAM,
      M_VIDEO_TEST, M_STREAM_TEST:             return ENG_PIX;
      default:                                 return ENG_NONE;
    endcase
  endfunction

endpackage

// File: rtl/link_mode_regs.sv
module link_mode_regs
  import link_mode_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  mode_e             status_mode,
  input  logic              switching,
  input  logic              pix_busy,
  input  logic              pix_fifo_nempty,
  input  logic              cmd_busy,
  input  logic              cmd_fifo_nempty,
  input  logic              cmd_rd_avail,
  output logic              power_up,
  output logic [2:0]        soft_rst_n,
  output mode_e             req_mode,
  output logic              manual_en
);

  localparam logic [ADDR_W-1:0] A_POWER  = ADDR_W'(REG_POWER);
  localparam logic [ADDR_W-1:0] A_SOFT   = ADDR_W'(REG_SOFT);
  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(REG_MODE);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
  localparam logic [ADDR_W-1:0] A_CORE   = ADDR_W'(REG_CORE);
  localparam logic [ADDR_W-1:0] A_MANUAL = ADDR_W'(REG_MANUAL);
  localparam logic [DATA_W-1:0] MODE_MAX = DATA_W'(MODE_LAST);

  logic mode_code_ok;
  logic [DATA_W-1:0] core_word;

  // any value above the last defined code leaves the request untouched
  assign mode_code_ok = (wr_data <= MODE_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      power_up   <= 1'b0;
      soft_rst_n <= 3'b111;
      req_mode   <= M_IDLE;
      manual_en  <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == A_POWER)  power_up   <= wr_data[0];
      if (wr_addr == A_SOFT)   soft_rst_n <= wr_data[2:0];
      if (wr_addr == A_MODE && mode_code_ok)
        req_mode <= mode_e'(wr_data[2:0]);
      if (wr_addr == A_MANUAL) manual_en  <= wr_data[0];
    end
  end

  always_comb begin
    core_word = '0;
    core_word[CF_CORE_BUSY] = pix_busy | cmd_busy | switching;
    core_word[CF_CORE_FIFO] = pix_fifo_nempty | cmd_fifo_nempty;
    core_word[CF_PIX_BUSY]  = pix_busy;
    core_word[CF_PIX_FIFO]  = pix_fifo_nempty;
    core_word[CF_CMD_BUSY]  = cmd_busy;
    core_word[CF_CMD_FIFO]  = cmd_fifo_nempty;
    core_word[CF_CMD_RDAVL] = cmd_rd_avail;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_POWER:  rd_data[0]   = power_up;
      A_SOFT:   rd_data[2:0] = soft_rst_n;
      A_MODE:   rd_data[2:0] = req_mode;
      A_STATUS: rd_data[2:0] = status_mode;
      A_CORE:   rd_data      = core_word;
      A_MANUAL: rd_data[0]   = manual_en;
      default:  rd_data      = '0;
    endcase
  end

endmodule

// File: rtl/link_mode_seq.sv
module link_mode_seq
  import link_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  mode_e req_mode,
  input  logic  pix_busy,
  input  logic  pix_ack,
  input  logic  cmd_busy,
  input  logic  cmd_ack,
  output mode_e status_mode,
  output logic  pix_req,
  output logic  cmd_req,
  output logic  switching
);

  seq_e  state;
  mode_e cur_mode;
  mode_e tgt_mode;
  eng_e  cur_eng;
  eng_e  tgt_eng;
  eng_e  drive_eng;
  logic  out_quiet;
  logic  in_acked;

  assign cur_eng = engine_of(cur_mode);
  assign tgt_eng = engine_of(tgt_mode);

  always_comb begin
    case (cur_eng)
      ENG_PIX: out_quiet = !pix_ack && !pix_busy;
      ENG_CMD: out_quiet = !cmd_ack && !cmd_busy;
      default: out_quiet = 1'b1;
    endcase
  end

  always_comb begin
    case (tgt_eng)
      ENG_PIX: in_acked = pix_ack;
      ENG_CMD: in_acked = cmd_ack;
      default: in_acked = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_HOLD;
      cur_mode <= M_IDLE;
      tgt_mode <= M_IDLE;
    end else if (!run) begin
      state    <= S_HOLD;
      cur_mode <= M_IDLE;
      tgt_mode <= M_IDLE;
    end else begin
      case (state)
        S_HOLD: begin
          if (req_mode != cur_mode) begin
            tgt_mode <= req_mode;
            state    <= S_DRAIN;
          end
        end
        S_DRAIN: begin
          if (out_quiet) begin
            if (tgt_eng == ENG_NONE) begin
              cur_mode <= tgt_mode;
              state    <= S_HOLD;
            end else begin
              state <= S_ENGAGE;
            end
          end
        end
        S_ENGAGE: begin
          if (in_acked) begin
            cur_mode <= tgt_mode;
            state    <= S_HOLD;
          end
        end
        default: state <= S_HOLD;
      endcase
    end
  end

  always_comb begin
    case (state)
      S_HOLD:   drive_eng = cur_eng;
      S_ENGAGE: drive_eng = tgt_eng;
      default:  drive_eng = ENG_NONE;
    endcase
  end

  assign pix_req     = run && (drive_eng == ENG_PIX);
  assign cmd_req     = run && (drive_eng == ENG_CMD);
  assign status_mode = run ? cur_mode : M_IDLE;
  assign switching   = run && (state != S_HOLD);

endmodule

// File: rtl/link_mode_ctrl.sv
module link_mode_ctrl
  import link_mode_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pix_busy_i,
  input  logic              pix_fifo_nempty_i,
  input  logic              cmd_busy_i,
  input  logic              cmd_fifo_nempty_i,
  input  logic              cmd_rd_avail_i,
  input  logic              pix_ack_i,
  input  logic              cmd_ack_i,
  output logic              pix_req_o,
  output logic              cmd_req_o,
  output logic              sys_rst_n_o,
  output logic              phy_rst_n_o,
  output logic              pix_rst_n_o,
  output logic              manual_timing_o,
  output logic [2:0]        mode_status_o
);

  logic       power_q;
  logic [2:0] soft_n;
  mode_e      req_mode;
  mode_e      status_mode;
  logic       switching;
  logic       run;

  link_mode_regs #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_en),
    .wr_addr         (wr_addr),
    .wr_data         (wr_data),
    .rd_addr         (rd_addr),
    .rd_data         (rd_data),
    .status_mode     (status_mode),
    .switching       (switching),
    .pix_busy        (pix_busy_i),
    .pix_fifo_nempty (pix_fifo_nempty_i),
    .cmd_busy        (cmd_busy_i),
    .cmd_fifo_nempty (cmd_fifo_nempty_i),
    .cmd_rd_avail    (cmd_rd_avail_i),
    .power_up        (power_q),
    .soft_rst_n      (soft_n),
    .req_mode        (req_mode),
    .manual_en       (manual_timing_o)
  );

  assign run = power_q && (&soft_n);

  link_mode_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .req_mode    (req_mode),
    .pix_busy    (pix_busy_i),
    .pix_ack     (pix_ack_i),
    .cmd_busy    (cmd_busy_i),
    .cmd_ack     (cmd_ack_i),
    .status_mode (status_mode),
    .pix_req     (pix_req_o),
    .cmd_req     (cmd_req_o),
    .switching   (switching)
  );

  assign sys_rst_n_o   = soft_n[SRST_SYS];
  assign phy_rst_n_o   = soft_n[SRST_PHY];
  assign pix_rst_n_o   = soft_n[SRST_PIX];
  assign mode_status_o = status_mode;

endmodule

// File: rtl/link_mode_sva.sv
module link_mode_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       power_q,
  input logic       sys_rst_n_o,
  input logic       phy_rst_n_o,
  input logic       pix_rst_n_o,
  input logic       pix_req_o,
  input logic       cmd_req_o,
  input logic       cmd_busy_i,
  input logic [2:0] mode_status_o
);

  AST_SOFTRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_rst_n_o && phy_rst_n_o && pix_rst_n_o) |-> (mode_status_o == 3'd0 && !pix_req_o && !cmd_req_o)); // R5

  AST_POWER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !power_q |-> (mode_status_o == 3'd0 && !pix_req_o && !cmd_req_o)); // R6

  AST_ENGINE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pix_req_o, cmd_req_o})); // R8

  AST_DRAIN_BEFORE_PIX: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pix_req_o) && $past(mode_status_o) == 3'd2) |-> !$past(cmd_busy_i)); // R7

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_status_o != 3'd7); // R3

endmodule

bind link_mode_ctrl link_mode_sva u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .power_q       (power_q),
  .sys_rst_n_o   (sys_rst_n_o),
  .phy_rst_n_o   (phy_rst_n_o),
  .pix_rst_n_o   (pix_rst_n_o),
  .pix_req_o     (pix_req_o),
  .cmd_req_o     (cmd_req_o),
  .cmd_busy_i    (cmd_busy_i),
  .mode_status_o (mode_status_o)
);

// File: tb/test_link_mode_ctrl.sv
module test_link_mode_ctrl;

  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic pix_busy = 1'b0, pix_fifo = 1'b0, cmd_busy = 1'b0, cmd_fifo = 1'b0, rd_avl = 1'b0;
  logic pix_ack, cmd_ack;
  logic pix_req, cmd_req, sys_n, phy_n, pixr_n, manual;
  logic [2:0] status;
  logic pix_ack_en = 1'b1, cmd_ack_en = 1'b1;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // engine model: acknowledge follows request one cycle later
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_ack <= 1'b0;
      cmd_ack <= 1'b0;
    end else begin
      pix_ack <= pix_req & pix_ack_en;
      cmd_ack <= cmd_req & cmd_ack_en;
    end
  end

  link_mode_ctrl #(.DATA_W(DW), .ADDR_W(AW)) i_link_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .pix_busy_i(pix_busy), .pix_fifo_nempty_i(pix_fifo), .cmd_busy_i(cmd_busy),
    .cmd_fifo_nempty_i(cmd_fifo), .cmd_rd_avail_i(rd_avl),
    .pix_ack_i(pix_ack), .cmd_ack_i(cmd_ack), .pix_req_o(pix_req), .cmd_req_o(cmd_req),
    .sys_rst_n_o(sys_n), .phy_rst_n_o(phy_n), .pix_rst_n_o(pixr_n),
    .manual_timing_o(manual), .mode_status_o(status)
  );

  task automatic check(input string req, input string what, input logic [DW-1:0] got,
                       input logic [DW-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    rd_addr = AW'(a);
    #1 d = rd_data;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_status(input logic [2:0] exp, input string req);
    logic [DW-1:0] v;
    for (int i = 0; i < 50; i++) begin
      rd(3, v);
      if (v[2:0] == exp) break;
      @(negedge clk);
    end
    rd(3, v);
    check(req, "mode status after switch", v, DW'(exp));
    check(req, "status port", DW'(status), DW'(exp));
  endtask

  task automatic t_reset_state();
    logic [DW-1:0] v;
    rd(3, v); check("R2", "status after reset", v, 0);
    rd(0, v); check("R6", "power after reset", v, 0);
    rd(1, v); check("R4", "soft reset word after reset", v, 7);
    check("R4", "reset pins", DW'({sys_n, phy_n, pixr_n}), 7);
    rd(5, v); check("R10", "manual after reset", v, 0);
    check("R8", "engine reqs after reset", DW'({pix_req, cmd_req}), 0);
  endtask

  task automatic t_power_gate();
    logic [DW-1:0] v;
    wr(2, 2);
    rd(2, v); check("R1", "mode request readback", v, 2);
    idle_cycles(10);
    rd(3, v); check("R6", "status while powered down", v, 0);
    check("R6", "cmd_req while powered down", DW'(cmd_req), 0);
    wr(0, 1);
    wait_status(3'd2, "R6");
    check("R8", "reqs in command", DW'({pix_req, cmd_req}), 2'b01);
  endtask

  task automatic t_undefined();
    logic [DW-1:0] v;
    wr(2, 7);
    idle_cycles(5);
    rd(2, v); check("R3", "request after code 7", v, 2);
    rd(3, v); check("R3", "status after code 7", v, 2);
    wr(2, 32'h0000_0103);
    idle_cycles(5);
    rd(2, v); check("R3", "request after wide code", v, 2);
  endtask

  task automatic t_drain();
    logic [DW-1:0] v;
    cmd_busy = 1'b1;
    wr(2, 3);
    idle_cycles(10);
    rd(3, v); check("R7", "status held while cmd busy", v, 2);
    check("R7", "reqs while draining", DW'({pix_req, cmd_req}), 0);
    rd(4, v); check("R9", "core word while cmd busy", v, 32'h0001_0001);
    cmd_busy = 1'b0;
    wait_status(3'd3, "R2");
    check("R8", "reqs in video", DW'({pix_req, cmd_req}), 2'b10);
  endtask

  task automatic t_ack_stall();
    logic [DW-1:0] v;
    pix_ack_en = 1'b0;
    idle_cycles(2);
    wr(2, 4);
    idle_cycles(10);
    rd(3, v); check("R7", "status held without ack", v, 3);
    check("R7", "incoming req raised", DW'(pix_req), 1);
    pix_ack_en = 1'b1;
    wait_status(3'd4, "R7");
  endtask

  task automatic t_modes();
    logic [DW-1:0] v;
    wr(2, 5); wait_status(3'd5, "R2");
    check("R8", "reqs in video test", DW'({pix_req, cmd_req}), 2'b10);
    wr(2, 6); wait_status(3'd6, "R2");
    wr(2, 1); wait_status(3'd1, "R1");
    check("R8", "reqs in autocalc", DW'({pix_req, cmd_req}), 0);
    idle_cycles(2);
    rd(4, v); check("R9", "core word quiet", v, 0);
    pix_busy = 1'b1; rd(4, v); check("R9", "pixel busy", v, 32'h0000_0101); pix_busy = 1'b0;
    pix_fifo = 1'b1; rd(4, v); check("R9", "pixel fifo", v, 32'h0000_0202); pix_fifo = 1'b0;
    cmd_fifo = 1'b1; rd(4, v); check("R9", "cmd fifo", v, 32'h0002_0002); cmd_fifo = 1'b0;
    rd_avl = 1'b1;   rd(4, v); check("R9", "read avail", v, 32'h0004_0000); rd_avl = 1'b0;
  endtask

  task automatic t_soft_reset();
    logic [DW-1:0] v;
    wr(2, 6); wait_status(3'd6, "R2");
    wr(1, 0);
    rd(3, v); check("R5", "status in soft reset", v, 0);
    check("R5", "reqs in soft reset", DW'({pix_req, cmd_req}), 0);
    check("R4", "pins all asserted", DW'({sys_n, phy_n, pixr_n}), 0);
    wr(1, 3);
    check("R4", "only system asserted", DW'({sys_n, phy_n, pixr_n}), 3'b011);
    idle_cycles(5);
    rd(3, v); check("R5", "status with system reset", v, 0);
    wr(1, 7);
    wait_status(3'd6, "R5");
  endtask

  task automatic t_manual();
    logic [DW-1:0] v;
    wr(5, 1);
    rd(5, v); check("R10", "manual readback", v, 1);
    check("R10", "manual pin", DW'(manual), 1);
    wr(5, 0);
    check("R10", "manual pin cleared", DW'(manual), 0);
  endtask

  task automatic t_power_down();
    logic [DW-1:0] v;
    wr(2, 2); wait_status(3'd2, "R2");
    wr(0, 0);
    rd(3, v); check("R6", "status after power clear", v, 0);
    check("R6", "cmd_req after power clear", DW'(cmd_req), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_power_gate();
    t_undefined();
    t_drain();
    t_ack_stall();
    t_modes();
    t_soft_reset();
    t_manual();
    t_power_down();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule